// File: doc/BRIEF.md
# Programmable Digital Crosspoint Array

This block is a sixteen-pin routing fabric in which any pin can be sent to any output. Each pin's input is conditioned by a per-pin stage (pass-through, flow-through latch or flip-flop) and placed on a shared routing pool. Each output cell builds a 4:1 multiplexer. Its four legs come from the four pin groups, one leg per group. The two select bits are pool signals that change at run time. A cell can merge the results of up to three cells below it into a mux as wide as 16:1. Its result then passes through its own output stage before it reaches the pad.

Each pad has an output enable taken from a routed pool signal, with a per-cell inversion bit. A cell can also be set to drive a constant level, which stands in for a jumper or a DIP switch. All routing state sits in a shadow register that is filled serially. The shadow is copied to the active register in one step, so the routing never uses a partly loaded setup. Pads stay undriven from reset until the first copy.

Top module: `xp_crosspoint`

## Requirements
- R1: From reset until the first `cfg_load_i` pulse, every bit of `pad_oe_o` is 0, whatever the pads and the shift input do.
- R2: While `cfg_shift_i` is high, each clock edge shifts `cfg_data_i` into the low end of a 704-bit shadow register, so the first bit sent ends up as the MSB. A `cfg_load_i` pulse copies the shadow into the active setup. Shifting without a load leaves the outputs unchanged.
- R3: The active vector holds cell 15 in its top 44 bits and cell 0 in its bottom 44. Inside each cell's slice, from MSB to LSB, the fields are: force_en, force_val, oe_inv, oe_src[3:0], in_mode[1:0], out_mode[1:0], ce_sel[2:0], ce_pin[3:0], casc_len[1:0], sel_src[3..0] (4 bits each, index 3 highest) and leg_sel[3..0] (2 bits each, index 3 highest). Mode code 0 is pass-through, 1 is latch, 2 is register, and 3 acts as pass-through.
- R4: Leg k of cell i's mux is pool bit 4*k + leg_sel[k], so group k (pins 4k to 4k+3) feeds only leg k.
- R5: Cell i's own result is leg number {pool[sel_src[1]], pool[sel_src[0]]}, and it follows changes on those pool bits with no clock edge.
- R6: Let L = min(casc_len, i) and h = {pool[sel_src[3]], pool[sel_src[2]]}. If L > 0 and 1 <= h <= L, the cell's mux output is the own result of cell i-h. Otherwise it is the cell's own result.
- R7: Pin i's input stage uses cell i's in_mode and clock enable. In register mode it changes only at an edge where the enable is high. In latch mode it follows the pad while the enable is high and holds the last captured value while the enable is low.
- R8: Cell i's output stage applies the same three modes to its mux output, using out_mode and the same clock enable.
- R9: A cell's clock enable is `gce_i[ce_sel[1:0]]` when ce_sel[2] is 0, and `pad_i[ce_pin]` when ce_sel[2] is 1.
- R10: Once configured, `pad_oe_o[i]` equals pool[oe_src] XOR oe_inv.
- R11: Once configured, a cell with force_en set drives `pad_o[i]` = force_val and `pad_oe_o[i]` = 1, whatever its mux and enable source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fabric and configuration clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_shift_i | input | 1 | Shift enable for the serial setup register |
| cfg_data_i | input | 1 | Serial setup data, first bit sent becomes the MSB |
| cfg_load_i | input | 1 | Copy shadow setup into the active setup |
| gce_i | input | 4 | Global clock enables |
| pad_i | input | 16 | Pad input levels |
| pad_o | output | 16 | Pad output levels |
| pad_oe_o | output | 16 | Pad output enables, 1 = driven |

## Verification
The assertions assume that `cfg_load_i` is a single-cycle pulse driven in step with the clock. They also assume that, apart from a load, the active setup changes only through that pulse. The register-hold property further assumes the output stage sees no reset during the cycle it checks. The stimulus changes pads, enables and the serial lines only at falling clock edges and raises the load strobe for exactly one cycle after a full 704-bit shift. Sweeps cover several pseudo-random pass-through setups that include cascades, forced cells and both enable polarities. Directed sequences then drive each stage mode with global and pin-derived enables.

// File: rtl/xp_pkg.sv
`timescale 1ns/1ps
package xp_pkg;
  parameter int XP_PINS = 16;
  parameter int XP_LEGS = 4;
  localparam int XP_GW = XP_PINS / XP_LEGS;
  localparam int XP_IW = $clog2(XP_PINS);
  localparam int XP_LW = $clog2(XP_GW);
  localparam int XP_SW = $clog2(XP_LEGS);

  typedef enum logic [1:0] {
    MODE_COMB  = 2'd0,
    MODE_LATCH = 2'd1,
    MODE_REG   = 2'd2,
    MODE_RSV   = 2'd3
  } path_mode_e;

  typedef struct packed {
    logic                            force_en;
    logic                            force_val;
    logic                            oe_inv;
    logic [XP_IW-1:0]                oe_src;
    path_mode_e                      in_mode;
    path_mode_e                      out_mode;
    logic [2:0]                      ce_sel;
    logic [XP_IW-1:0]                ce_pin;
    logic [1:0]                      casc_len;
    logic [XP_LEGS-1:0][XP_IW-1:0]   sel_src;
    logic [XP_LEGS-1:0][XP_LW-1:0]   leg_sel;
  } cell_cfg_t;

  localparam int CELL_CFG_W = $bits(cell_cfg_t);
  localparam int ARRAY_CFG_W = CELL_CFG_W * XP_PINS;
endpackage

// File: rtl/xp_cfg_chain.sv
`timescale 1ns/1ps
module xp_cfg_chain #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         data_i,
  input  logic         load_i,
  output logic [W-1:0] active_o,
  output logic         valid_o
);
  logic [W-1:0] shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
    end else if (shift_i) begin
      shadow_q <= {shadow_q[W-2:0], data_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= '0;
      valid_o  <= 1'b0;
    end else if (load_i) begin
      active_o <= shadow_q;
      valid_o  <= 1'b1;
    end
  end
endmodule

// File: rtl/xp_stage.sv
`timescale 1ns/1ps
module xp_stage
  import xp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  path_mode_e mode_i,
  input  logic       ce_i,
  input  logic       d_i,
  output logic       q_o
);
  // one storage bit serves both latch (flow-through) and register modes
  logic held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   held_q <= 1'b0;
    else if (ce_i) held_q <= d_i;
  end

  always_comb begin
    unique case (mode_i)
      MODE_LATCH: q_o = ce_i ? d_i : held_q;
      MODE_REG:   q_o = held_q;
      default:    q_o = d_i;
    endcase
  end
endmodule

// File: rtl/xp_cell.sv
`timescale 1ns/1ps
module xp_cell
  import xp_pkg::*;
(
  input  logic [XP_PINS-1:0] pool_i,
  input  cell_cfg_t          cfg_i,
  output logic               r_o,
  output logic [1:0]         hi_o
);
  logic [XP_LEGS-1:0] leg;
  logic [XP_SW-1:0]   sel;

  for (genvar k = 0; k < XP_LEGS; k++) begin : g_leg
    assign leg[k] = pool_i[XP_IW'(k * XP_GW) + XP_IW'(cfg_i.leg_sel[k])];
  end

  assign sel  = {pool_i[cfg_i.sel_src[1]], pool_i[cfg_i.sel_src[0]]};
  assign r_o  = leg[sel];
  assign hi_o = {pool_i[cfg_i.sel_src[3]], pool_i[cfg_i.sel_src[2]]};
endmodule

// File: rtl/xp_crosspoint.sv
`timescale 1ns/1ps
module xp_crosspoint
  import xp_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_shift_i,
  input  logic               cfg_data_i,
  input  logic               cfg_load_i,
  input  logic [3:0]         gce_i,
  input  logic [XP_PINS-1:0] pad_i,
  output logic [XP_PINS-1:0] pad_o,
  output logic [XP_PINS-1:0] pad_oe_o
);
  localparam int N = XP_PINS;
  localparam int UPW = 3;

  logic [ARRAY_CFG_W-1:0] act_vec;
  logic                   cfg_valid;
  cell_cfg_t [N-1:0]      cfg_q;
  logic [N-1:0]           cell_ce;
  logic [N-1:0]           pool;
  logic [N-1:0]           own_r;
  logic [N+UPW-1:0]       r_pad;
  logic [N-1:0]           mux_o;
  logic [N-1:0]           stage_o;

  xp_cfg_chain #(.W(ARRAY_CFG_W)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .shift_i  (cfg_shift_i),
    .data_i   (cfg_data_i),
    .load_i   (cfg_load_i),
    .active_o (act_vec),
    .valid_o  (cfg_valid)
  );

  assign cfg_q = act_vec;
  assign r_pad = {own_r, {UPW{1'b0}}};

  for (genvar i = 0; i < N; i++) begin : g_cell
    localparam logic [1:0] MAX_UP = (i > 3) ? 2'd3 : 2'(i);
    logic [1:0] hi;
    logic [1:0] eff_len;

    assign cell_ce[i] = cfg_q[i].ce_sel[2] ? pad_i[cfg_q[i].ce_pin]
                                           : gce_i[cfg_q[i].ce_sel[1:0]];

    xp_stage u_in (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .mode_i (cfg_q[i].in_mode),
      .ce_i   (cell_ce[i]),
      .d_i    (pad_i[i]),
      .q_o    (pool[i])
    );

    xp_cell u_mux (
      .pool_i (pool),
      .cfg_i  (cfg_q[i]),
      .r_o    (own_r[i]),
      .hi_o   (hi)
    );

    // cascade: high select picks a cell up to eff_len below this one
    assign eff_len = (cfg_q[i].casc_len > MAX_UP) ? MAX_UP : cfg_q[i].casc_len;

    always_comb begin
      mux_o[i] = own_r[i];
      if (eff_len != 2'd0 && hi != 2'd0 && hi <= eff_len) begin
        unique case (hi)
          2'd1:    mux_o[i] = r_pad[i+2];
          2'd2:    mux_o[i] = r_pad[i+1];
          default: mux_o[i] = r_pad[i];
        endcase
      end
    end

    xp_stage u_out (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .mode_i (cfg_q[i].out_mode),
      .ce_i   (cell_ce[i]),
      .d_i    (mux_o[i]),
      .q_o    (stage_o[i])
    );

    assign pad_o[i]    = cfg_q[i].force_en ? cfg_q[i].force_val : stage_o[i];
    assign pad_oe_o[i] = cfg_valid &
                         (cfg_q[i].force_en | (pool[cfg_q[i].oe_src] ^ cfg_q[i].oe_inv));
  end
endmodule

// File: rtl/xp_crosspoint_chk.sv
`timescale 1ns/1ps
module xp_crosspoint_chk
  import xp_pkg::*;
(
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       cfg_load_i,
  input logic                       cfg_valid,
  input cell_cfg_t [XP_PINS-1:0]    cfg_q,
  input logic [XP_PINS-1:0]         cell_ce,
  input logic [XP_PINS-1:0]         pad_o,
  input logic [XP_PINS-1:0]         pad_oe_o
);
  assert_hiz_unconfigured_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_valid |-> (pad_oe_o == '0));

  assert_valid_sticky_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid |=> cfg_valid);

  assert_atomic_update_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_load_i |=> $stable(cfg_q));

  for (genvar i = 0; i < XP_PINS; i++) begin : g_chk
    assert_force_drive_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_valid && cfg_q[i].force_en) |-> (pad_oe_o[i] && pad_o[i] == cfg_q[i].force_val));

    assert_reg_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_valid && !cfg_load_i && cfg_q[i].out_mode == MODE_REG &&
       !cfg_q[i].force_en && !cell_ce[i]) |=> $stable(pad_o[i]));
  end
endmodule

bind xp_crosspoint xp_crosspoint_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_load_i (cfg_load_i),
  .cfg_valid  (cfg_valid),
  .cfg_q      (cfg_q),
  .cell_ce    (cell_ce),
  .pad_o      (pad_o),
  .pad_oe_o   (pad_oe_o)
);

// File: tb/sim_xp_crosspoint.sv
`timescale 1ns/1ps
module sim_xp_crosspoint;
  import xp_pkg::*;

  localparam int NP = 16;
  localparam int CW = $bits(cell_cfg_t);
  localparam int TOT = NP * CW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_shift = 1'b0;
  logic cfg_data = 1'b0;
  logic cfg_load = 1'b0;
  logic [3:0] gce = 4'h0;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out;
  logic [NP-1:0] pad_oe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  cell_cfg_t act [NP];
  cell_cfg_t nxt [NP];

  always #10 clk = ~clk;

  xp_crosspoint u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cfg_shift_i (cfg_shift),
    .cfg_data_i  (cfg_data),
    .cfg_load_i  (cfg_load),
    .gce_i       (gce),
    .pad_i       (pad_in),
    .pad_o       (pad_out),
    .pad_oe_o    (pad_oe)
  );

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  task automatic chk(input string req, input logic [NP-1:0] act_v, input logic [NP-1:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act_v, exp_v, $time);
    end
  endtask

  // build vector: cell 15 on top, first bit sent is MSB
  task automatic shift_nxt();
    logic [TOT-1:0] v;
    for (int i = 0; i < NP; i++) v[i*CW +: CW] = nxt[i];
    for (int b = TOT - 1; b >= 0; b--) begin
      @(negedge clk);
      cfg_shift = 1'b1;
      cfg_data  = v[b];
    end
    @(negedge clk);
    cfg_shift = 1'b0;
  endtask

  task automatic pulse_load();
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    act = nxt;
  endtask

  function automatic logic own_res(int i, logic [NP-1:0] p);
    logic [1:0] s;
    logic [3:0] legs;
    for (int k = 0; k < 4; k++) legs[k] = p[k*4 + int'(act[i].leg_sel[k])];
    s = {p[act[i].sel_src[1]], p[act[i].sel_src[0]]};
    return legs[s];
  endfunction

  function automatic logic [NP-1:0] exp_out(logic [NP-1:0] p);
    logic [NP-1:0] o;
    for (int i = 0; i < NP; i++) begin
      int l, h;
      l = int'(act[i].casc_len);
      if (l > i) l = i;
      h = int'({p[act[i].sel_src[3]], p[act[i].sel_src[2]]});
      if (l > 0 && h >= 1 && h <= l) o[i] = own_res(i - h, p);
      else o[i] = own_res(i, p);
      if (act[i].force_en) o[i] = act[i].force_val;
    end
    return o;
  endfunction

  function automatic logic [NP-1:0] exp_oe(logic [NP-1:0] p);
    logic [NP-1:0] o;
    for (int i = 0; i < NP; i++)
      o[i] = act[i].force_en | (p[act[i].oe_src] ^ act[i].oe_inv);
    return o;
  endfunction

  task automatic rand_cfg(input int variant);
    for (int i = 0; i < NP; i++) begin
      logic [31:0] a, b;
      a = rnd();
      b = rnd();
      nxt[i] = '0;
      nxt[i].in_mode  = MODE_COMB;
      nxt[i].out_mode = (variant == 2 && i[0]) ? MODE_RSV : MODE_COMB;
      for (int k = 0; k < 4; k++) begin
        nxt[i].leg_sel[k] = a[2*k +: 2];
        nxt[i].sel_src[k] = b[4*k +: 4];
      end
      nxt[i].casc_len  = a[9:8];
      if (i == 3 || i == 7 || i == 15) nxt[i].casc_len = 2'd3;
      nxt[i].oe_src    = a[15:12];
      nxt[i].oe_inv    = a[16];
      nxt[i].force_en  = (a[20:18] == 3'd0);
      nxt[i].force_val = a[21];
    end
  endtask

  task automatic sweep(input int n, input string req);
    for (int t = 0; t < n; t++) begin
      @(negedge clk);
      pad_in = rnd()[NP-1:0];
      #2;
      chk(req, pad_out, exp_out(pad_in));
      chk("R10 R11 oe", pad_oe, exp_oe(pad_in));
    end
  endtask

  task automatic drive(input int pin, input logic v);
    @(negedge clk);
    pad_in[pin] = v;
    #2;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NP; i++) begin act[i] = '0; nxt[i] = '0; end
    repeat (3) @(negedge clk);
    #2;
    chk("R1 oe in reset", pad_oe, '0);
    rst_n = 1'b1;

    // R1/R2: shift without load keeps pads undriven
    rand_cfg(0);
    shift_nxt();
    pad_in = 16'hffff;
    #2;
    chk("R1 unloaded after shift", pad_oe, '0);
    pulse_load();

    // R4 R5 R6: random pass-through setups with cascades
    sweep(150, "R4 R5 R6 cfg0");
    rand_cfg(1);
    shift_nxt();
    pulse_load();
    sweep(150, "R4 R5 R6 cfg1");

    // R2: new image shifted but not loaded leaves outputs on the old one
    rand_cfg(2);
    shift_nxt();
    sweep(40, "R2 no load");
    pulse_load();
    sweep(150, "R4 R5 R6 R3 cfg2");

    // R3: single forced cell, field position check
    for (int i = 0; i < NP; i++) begin
      nxt[i] = '0;
      nxt[i].oe_src = 4'd15;
    end
    nxt[0].force_en  = 1'b1;
    nxt[0].force_val = 1'b1;
    shift_nxt();
    pulse_load();
    pad_in = '0;
    #2;
    chk("R3 layout force cell0 out", pad_out & 16'h0001, 16'h0001);
    chk("R3 layout oe", pad_oe, 16'h0001);

    // directed mode setup
    for (int i = 0; i < NP; i++) begin
      nxt[i] = '0;
      nxt[i].oe_src = 4'd15;
      nxt[i].oe_inv = 1'b1;
      for (int k = 0; k < 4; k++) nxt[i].sel_src[k] = 4'd15;
    end
    nxt[0].in_mode = MODE_REG;   nxt[0].ce_sel = 3'd0;
    nxt[1].in_mode = MODE_LATCH; nxt[1].ce_sel = 3'd4; nxt[1].ce_pin = 4'd14;
    nxt[1].leg_sel[0] = 2'd1;
    nxt[2].out_mode = MODE_REG;  nxt[2].ce_sel = 3'd1;
    nxt[2].leg_sel[0] = 2'd2;
    nxt[3].out_mode = MODE_LATCH; nxt[3].ce_sel = 3'd4; nxt[3].ce_pin = 4'd13;
    nxt[3].leg_sel[0] = 2'd3;
    nxt[4].oe_src = 4'd12; nxt[4].oe_inv = 1'b0;
    nxt[5].oe_src = 4'd12; nxt[5].oe_inv = 1'b1;
    shift_nxt();
    pulse_load();

    // preload every stage with 0
    @(negedge clk);
    gce = 4'hf;
    pad_in = 16'h6000;
    @(negedge clk);
    gce = 4'h0;
    pad_in = 16'h0000;
    #2;
    chk("R7 R8 preload", pad_out & 16'h000f, 16'h0000);

    // R7 register input, global enable
    drive(0, 1'b1);
    @(negedge clk); #2;
    chk("R7 reg hold ce low", pad_out & 16'h0001, 16'h0000);
    gce[0] = 1'b1;
    #2;
    chk("R7 reg not transparent", pad_out & 16'h0001, 16'h0000);
    @(negedge clk); #2;
    chk("R7 reg capture", pad_out & 16'h0001, 16'h0001);
    gce[0] = 1'b0;

    // R7 latch input, R9 pin-derived enable (pin 14)
    @(negedge clk);
    pad_in[14] = 1'b1;
    pad_in[1]  = 1'b1;
    #2;
    chk("R7 R9 latch open", pad_out & 16'h0002, 16'h0002);
    @(negedge clk);
    pad_in[14] = 1'b0;
    pad_in[1]  = 1'b0;
    #2;
    chk("R7 R9 latch hold", pad_out & 16'h0002, 16'h0002);
    @(negedge clk); #2;
    chk("R7 latch hold edge", pad_out & 16'h0002, 16'h0002);
    pad_in[14] = 1'b1;
    #2;
    chk("R7 latch reopen", pad_out & 16'h0002, 16'h0000);

    // R8 register output, gce[1]
    @(negedge clk);
    gce[1] = 1'b1;
    pad_in[2] = 1'b1;
    #2;
    chk("R8 reg before edge", pad_out & 16'h0004, 16'h0000);
    @(negedge clk); #2;
    chk("R8 reg after edge", pad_out & 16'h0004, 16'h0004);
    gce[1] = 1'b0;
    pad_in[2] = 1'b0;
    @(negedge clk); #2;
    chk("R8 R9 reg hold gce low", pad_out & 16'h0004, 16'h0004);

    // R8 latch output, pin 13 enable
    @(negedge clk);
    pad_in[13] = 1'b1;
    pad_in[3]  = 1'b1;
    #2;
    chk("R8 latch open", pad_out & 16'h0008, 16'h0008);
    @(negedge clk);
    pad_in[13] = 1'b0;
    pad_in[3]  = 1'b0;
    #2;
    chk("R8 latch hold", pad_out & 16'h0008, 16'h0008);

    // R10 polarity on cells 4 and 5
    drive(12, 1'b1);
    chk("R10 oe pin high", pad_oe & 16'h0030, 16'h0010);
    drive(12, 1'b0);
    chk("R10 oe pin low", pad_oe & 16'h0030, 16'h0020);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule